// File: doc/BRIEF.md
# Flow-Through Burst SRAM Model

This block is a synthesizable model of a synchronous static RAM with byte lanes and a two-bit burst address counter. Control inputs are sampled on the rising clock. Two address strobes can open an access: a processor-side strobe and a controller-side strobe. Three chip selects are checked only on a strobe edge. Once an access is open, an advance input steps the low two address bits through a four-word burst. The burst order is linear or interleaved, chosen by a mode input.

Reads are flow-through. The word at the address latched on an edge appears on the data output in the cycle after that edge, through combinational logic only, with no output register. Writes land on the edge they are presented. Each byte lane is nine bits wide: eight data bits plus one parity bit. A global write stores all lanes. Otherwise the byte-write enable qualifies a per-lane select.

An asynchronous output enable and a sleep input gate the output. When the output is not driven, the valid flag is low and the data bus reads as all zeros, which stands for high impedance.

Top module: `ftb_sram`

## Requirements
- R1: After reset, `rvalid` is 0 and `rdata` is all zeros, even with the output enable active.
- R2: A clock edge with `adsp_n` or `adsc_n` low opens an access at `addr` (burst count 0) only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0. If any one of these is in the other state, the block is deselected and `rvalid` goes low.
- R3: On edges without a strobe, the chip selects are ignored. An open access stays valid and keeps its address.
- R4: Read data is combinational from the current address. The word addressed by an edge, including a word written on that same edge, is on `rdata` within the cycle that follows it.
- R5: With `burst_mode`=0 (linear), each edge with `adv_n`=0 and no strobe moves the low two address bits to base+count modulo 4. The upper bits stay at the base address.
- R6: With `burst_mode`=1 (interleaved), the low two address bits are base XOR count.
- R7: The two-bit burst count wraps from 3 to 0. On an edge with `adv_n`=1 and no strobe, the address is held.
- R8: With `gw_n`=0, a write stores all lanes of `wdata`, whatever `bwe_n` and `bw_n` are.
- R9: With `gw_n`=1 and `bwe_n`=0, only lane i with `bw_n[i]`=0 is written. Lane i is `wdata[9i+8:9i]`, and bit 8 of each lane is the parity bit.
- R10: With `gw_n`=1 and `bwe_n`=1, the cycle is a read and the array is left unchanged.
- R11: On an edge where `adsp_n` is low, write controls are ignored and the access is a read.
- R12: With `oe_n`=1, `rvalid` is 0 and `rdata` is zero at once, without a clock edge. Setting `oe_n` back to 0 restores the read data.
- R13: While `sleep`=1, the output is undriven at once. Edges ignore strobes, advance and writes, and the access state is held for when `sleep` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | ADDR_W | Word address, latched on a strobe |
| adsp_n | input | 1 | Processor-side strobe, active low, read-only start |
| adsc_n | input | 1 | Controller-side strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select 1, active low |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| burst_mode | input | 1 | 0 linear, 1 interleaved |
| sleep | input | 1 | Low-power state, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 9*LANES | Write data, nine bits per lane |
| rdata | output | 9*LANES | Read data, zero when undriven |
| rvalid | output | 1 | High while `rdata` is driven |

## Verification
The assertions assume that `addr`, the strobes, `adv_n`, the write controls, the chip selects and `sleep` are stable around the rising edge, and that `burst_mode` changes only between bursts, never in the middle of one. The bench meets this by changing every input on the falling edge and sampling at the following falling edge. It switches `burst_mode` only just before a strobe. It changes `oe_n` and `sleep` between edges to show their asynchronous effect. The bench also writes every word it later reads, because the array has no reset.

// File: rtl/ftb_sram_pkg.sv
`timescale 1ns/1ps
package ftb_sram_pkg;
  localparam int LANE_W = 9;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  // low two address bits for a given burst count
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input burst_order_e order);
    burst_low = (order == ORDER_INTERLEAVE) ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/ftb_burst_seq.sv
`timescale 1ns/1ps
module ftb_burst_seq
  import ftb_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic              sel_ok,
  input  logic              adv,
  input  burst_order_e      order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              act_nxt,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic              act_q,
  output logic [ADDR_W-1:0] addr_cur
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        cnt_q, cnt_n;
  logic              act_n;

  always_comb begin
    base_n = base_q;
    cnt_n  = cnt_q;
    act_n  = act_q;
    if (start) begin
      act_n = sel_ok;
      if (sel_ok) begin
        base_n = addr_in;
        cnt_n  = 2'd0;
      end
    end else if (act_q && adv) begin
      cnt_n = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (run) begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
    end
  end

  assign act_nxt  = act_n;
  assign addr_nxt = {base_n[ADDR_W-1:2], burst_low(base_n[1:0], cnt_n, order)};
  assign addr_cur = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, order)};

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && sel_ok) |=> (cnt_q == 2'd0) && (base_q == $past(addr_in)) && act_q);
  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !sel_ok) |=> !act_q);
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && act_q && adv) |=> (cnt_q == $past(cnt_q) + 2'd1));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !adv) |=> $stable(cnt_q) && $stable(base_q) && $stable(act_q));
  p_sleep_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q) && $stable(base_q) && $stable(act_q));
endmodule

// File: rtl/ftb_write_ctrl.sv
`timescale 1ns/1ps
module ftb_write_ctrl #(
  parameter int LANES = 4
) (
  input  logic             go,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we
);
  always_comb begin
    lane_we = '0;
    if (go) begin
      if (!gw_n)       lane_we = '1;
      else if (!bwe_n) lane_we = ~bw_n;
    end
  end
endmodule

// File: rtl/ftb_array.sv
`timescale 1ns/1ps
module ftb_array
  import ftb_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/ftb_sram.sv
`timescale 1ns/1ps
module ftb_sram
  import ftb_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    burst_mode,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DW = LANES * LANE_W;

  if (LANES != 2 && LANES != 4) begin : g_bad_lanes
    initial $error("LANES must be 2 or 4");
  end

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  logic              run, start, sel_ok, act_nxt, act_q, go;
  logic [ADDR_W-1:0] addr_nxt, addr_cur;
  logic [LANES-1:0]  lane_we;
  logic [DW-1:0]     arr_rd;
  burst_order_e      order;

  assign run    = !sleep;
  assign start  = !adsp_n || !adsc_n;
  assign sel_ok = !ce1_n && ce2 && !ce3_n;
  assign order  = burst_order_e'(burst_mode);
  assign go     = run && act_nxt && adsp_n;

  ftb_burst_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_q), .run(run), .start(start), .sel_ok(sel_ok),
    .adv(!adv_n), .order(order), .addr_in(addr),
    .act_nxt(act_nxt), .addr_nxt(addr_nxt), .act_q(act_q), .addr_cur(addr_cur)
  );

  ftb_write_ctrl #(.LANES(LANES)) wctl_i (
    .go(go), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .lane_we(lane_we)
  );

  ftb_array #(.ADDR_W(ADDR_W), .LANES(LANES)) arr_i (
    .clk(clk), .lane_we(lane_we), .waddr(addr_nxt), .wdata(wdata),
    .raddr(addr_cur), .rdata(arr_rd)
  );

  assign rvalid = act_q && !oe_n && !sleep;
  assign rdata  = rvalid ? arr_rd : '0;

  p_oe_r12: assert property (@(posedge clk) disable iff (!rst_q)
    oe_n |-> !rvalid);
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_q)
    !rvalid |-> (rdata == '0));
  p_adsp_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !adsp_n |-> (lane_we == '0));
  p_gw_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (run && act_nxt && adsp_n && !gw_n) |-> (lane_we == '1));
  p_read_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (gw_n && bwe_n) |-> (lane_we == '0));
  p_sleepwr_r13: assert property (@(posedge clk) disable iff (!rst_q)
    sleep |-> (lane_we == '0) && !rvalid);
endmodule

// File: tb/ftb_sram_tb.sv
`timescale 1ns/1ps
module ftb_sram_tb_top;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int DW = 9 * LN;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n;
  logic [LN-1:0] bw_n;
  logic burst_mode, sleep, oe_n;
  logic [DW-1:0] wdata, rdata;
  logic rvalid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ftb_sram #(.ADDR_W(AW), .LANES(LN)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .burst_mode(burst_mode), .sleep(sleep),
    .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  localparam logic [DW-1:0] D0 = {9'h011, 9'h122, 9'h033, 9'h144};
  localparam logic [DW-1:0] D1 = {9'h101, 9'h022, 9'h133, 9'h044};
  localparam logic [DW-1:0] D2 = {9'h055, 9'h166, 9'h077, 9'h188};
  localparam logic [DW-1:0] D3 = {9'h0AB, 9'h1CD, 9'h0EF, 9'h100};
  localparam logic [DW-1:0] D4 = {9'h0F0, 9'h00F, 9'h1E1, 9'h12E};
  localparam logic [DW-1:0] WB = {9'h1AA, 9'h1BB, 9'h1CC, 9'h1DD};
  localparam logic [DW-1:0] DM = {9'h101, 9'h1BB, 9'h133, 9'h1DD};
  localparam logic [DW-1:0] ONES = '1;

  typedef struct packed {
    logic adsp_n, adsc_n, adv_n, gw_n, bwe_n;
    logic [3:0] bw_n;
    logic [5:0] addr;
    logic [35:0] wd;
    logic ev;
    logic [35:0] ed;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd8,  D0,   1'b1, D0, 4'd4},   // R4 write then flow-through read
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd9,  D1,   1'b1, D1, 4'd2},   // R2 controller strobe start
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd10, D2,   1'b1, D2, 4'd8},   // R8
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'd11, D3,   1'b1, D3, 4'd8},   // R8
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 6'd9,  ONES, 1'b1, D1, 4'd11},  // R11 processor strobe write ignored
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0,  ONES, 1'b1, D2, 4'd5},   // R5 linear 9->10
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0,  ONES, 1'b1, D3, 4'd5},   // R5 ->11
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0,  ONES, 1'b1, D0, 4'd5},   // R5 ->8
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0,  ONES, 1'b1, D1, 4'd7},   // R7 wrap ->9
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0,  ONES, 1'b1, D1, 4'd7},   // R7 hold
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'hA, 6'd0,  WB,   1'b1, DM, 4'd9},   // R9 lanes 0 and 2
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 6'd0,  ONES, 1'b1, DM, 4'd10},  // R10 no write
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 6'd0,  D4,   1'b1, D4, 4'd8}    // R8 global overrides
  };

  task automatic chk(input string req, input logic v, input logic [DW-1:0] d,
                     input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (v !== ev || d !== ed) begin
      errors++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               req, v, d, ev, ed);
    end
  endtask

  task automatic idle;
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; wdata = '0; addr = '0;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_at(input logic [AW-1:0] a);
    idle();
    adsc_n = 1'b0; addr = a;
    tick();
    idle();
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    burst_mode = 1'b0; sleep = 1'b0; oe_n = 1'b0;
    repeat (3) tick();
    chk("R1 in reset", rvalid, rdata, 1'b0, '0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 after reset", rvalid, rdata, 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      adsp_n = VECS[i].adsp_n; adsc_n = VECS[i].adsc_n; adv_n = VECS[i].adv_n;
      gw_n = VECS[i].gw_n; bwe_n = VECS[i].bwe_n; bw_n = VECS[i].bw_n;
      addr = VECS[i].addr; wdata = VECS[i].wd;
      tick();
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), rvalid, rdata,
          VECS[i].ev, VECS[i].ed);
    end
    idle();

    // R3: selects change without a strobe
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
    tick();
    chk("R3 selects ignored", rvalid, rdata, 1'b1, D4);

    // R2: each select alone deselects on a strobe
    for (int k = 0; k < 3; k++) begin
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
      start_at(6'd8);
      chk("R2 select reopen", rvalid, rdata, 1'b1, D0);
      if (k == 0) ce1_n = 1'b1;
      if (k == 1) ce2 = 1'b0;
      if (k == 2) ce3_n = 1'b1;
      start_at(6'd8);
      chk("R2 deselect", rvalid, rdata, 1'b0, '0);
    end
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;

    // R6: interleaved from base 9: 9, 8, 11, 10
    burst_mode = 1'b1;
    start_at(6'd9);
    chk("R6 first", rvalid, rdata, 1'b1, D4);
    adv_n = 1'b0; tick();
    chk("R6 second", rvalid, rdata, 1'b1, D0);
    tick();
    chk("R6 third", rvalid, rdata, 1'b1, D3);
    tick();
    chk("R6 fourth", rvalid, rdata, 1'b1, D2);
    adv_n = 1'b1;

    // R12: output enable acts without a clock
    #1 oe_n = 1'b1;
    #1 chk("R12 oe off", rvalid, rdata, 1'b0, '0);
    oe_n = 1'b0;
    #1 chk("R12 oe on", rvalid, rdata, 1'b1, D2);

    // R13: sleep
    @(negedge clk);
    sleep = 1'b1;
    #1 chk("R13 sleep output", rvalid, rdata, 1'b0, '0);
    adsc_n = 1'b0; addr = 6'd8; gw_n = 1'b0; wdata = ONES; adv_n = 1'b0;
    tick();
    chk("R13 sleep edge", rvalid, rdata, 1'b0, '0);
    idle();
    sleep = 1'b0;
    #1 chk("R13 state held", rvalid, rdata, 1'b1, D2);
    start_at(6'd8);
    chk("R13 write ignored", rvalid, rdata, 1'b1, D0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule